// File: doc/BRIEF.md
# ADC Sample Result Bank

This block stores conversion results for a set of sample slots (19 by default) on the digital side of an analog-to-digital converter. Each time the converter finishes a conversion it raises a one-cycle strobe carrying the raw 12-bit code, the slot index, a 2-bit resolution code and a format bit. The block trims the code to the chosen resolution, widens it to a 16-bit result field (zero- or sign-extended), writes it into that slot and raises the slot's valid flag. If a slot is written again before anyone has read it, the slot's overrun flag is raised as well.

Software or any other consumer reads a slot through a combinational read port. The returned word carries the result together with the flags as they stood before the read, and the read clears both flags on the following clock edge. Two summary outputs report whether any slot holds unread data or has lost data, and a packed status word exposes the flags of the low sixteen slots. When the double-buffer parameter is set and the mode input is high, each slot gets a second result register that takes a new result while the first one is still unread.

Top module: `adc_result_bank`

## Requirements
- R1: When the format bit is 0, result bits [15:12] are zero and the trimmed code sits in bits [11:0].
- R2: When the format bit is 1, result bits [15:12] all equal bit 11 of the trimmed code.
- R3: A strobe for slot s makes the read word of slot s show the new result with the valid flag (read bit 17) set from the next cycle on.
- R4: A strobe for a slot whose primary valid flag is already set, with no read of that register in the same cycle, sets the overrun flag (read bit 16); the overrun flag is only ever set while the valid flag is set.
- R5: A read of a slot returns the flags as they were before the read and clears that register's valid and overrun flags on the next edge; the stored result value is kept.
- R6: Resolution code 0, 1, 2, 3 keeps 6, 8, 10, 12 low bits of the raw code; all higher raw bits are forced to zero before the extension of R1/R2.
- R7: anyValid is high exactly while some slot has a valid flag set (primary or secondary); anyOverrun likewise for overrun flags.
- R8: statusWord bit i (i = 0..15) is the primary valid flag of slot i and bit 16+i is its primary overrun flag.
- R9: When a strobe and a read hit the same register of the same slot in one cycle, the read returns the old contents, and afterwards the register holds the new result with valid set and overrun clear.
- R10: With double-buffer mode high (read select rdSec = 1 picks the second register), a strobe goes to the second register only while the primary valid flag is set; otherwise it goes to the primary register.
- R11: With double-buffer mode low, the second register is never written, and a read of it clears only its own flags, never those of the primary register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cvtStb | input | 1 | One-cycle strobe: a conversion result is available |
| cvtSlot | input | 5 | Slot index of the delivered result |
| cvtRaw | input | 12 | Raw conversion code |
| cvtRes | input | 2 | Resolution code (0: 6 bits, 1: 8, 2: 10, 3: 12) |
| cvtSigned | input | 1 | Format bit: 0 zero-extend, 1 sign-extend |
| dblMode | input | 1 | Double-buffer mode enable |
| rdEn | input | 1 | Read strobe; clears the addressed register's flags |
| rdSlot | input | 5 | Slot index to read |
| rdSec | input | 1 | Read select: 0 primary, 1 second register |
| rdData | output | 18 | {valid, overrun, result[15:0]} of the addressed register |
| anyValid | output | 1 | Some slot holds unread data |
| anyOverrun | output | 1 | Some slot has an overrun flag set |
| statusWord | output | 32 | Primary overrun flags of slots 15..0 in [31:16], valid flags in [15:0] |

## Verification
The write of a fresh result and the clearing read can strike the same slot in the same cycle, and the outcome decides whether a sample is silently lost or falsely flagged. The bench provokes this by raising the conversion strobe and the read strobe for one slot on the same negative clock edge: the read word sampled in that cycle must still show the old result, and a later read must show the new result with valid set and overrun clear. The same collision is also guarded by a property on the flag registers, and double-buffer routing is judged by reading both registers of a slot after two back-to-back results.

// File: rtl/adc_bank_pkg.sv
package adc_bank_pkg;

  localparam int SLOT_W = 5;
  localparam int RAW_W  = 12;
  localparam int DATA_W = 16;

  // Strobes from the control decode to the storage datapath.
  typedef struct packed {
    logic              wrPri;
    logic              wrSec;
    logic [SLOT_W-1:0] wrSlot;
    logic              clrPri;
    logic              clrSec;
    logic              rdSecSel;
    logic [SLOT_W-1:0] rdSlot;
  } bankCmd_t;

endpackage

// File: rtl/adc_result_fmt.sv
module adc_result_fmt #(
  parameter int RAW_W  = 12,
  parameter int DATA_W = 16
) (
  input  logic [RAW_W-1:0]  rawCode,
  input  logic [1:0]        resSel,
  input  logic              signedFmt,
  output logic [DATA_W-1:0] fmtData
);

  localparam int MIN_BITS = RAW_W - 6;
  localparam int EXT_W    = DATA_W - RAW_W;

  logic [RAW_W-1:0] trimmed;
  logic [4:0]       keepBits;

  always_comb begin
    keepBits = 5'(MIN_BITS) + {2'b00, resSel, 1'b0};
    for (int i = 0; i < RAW_W; i++) begin
      trimmed[i] = rawCode[i] && (i < int'(keepBits));
    end
  end

  generate
    if (EXT_W > 0) begin : g_ext
      assign fmtData = signedFmt ? {{EXT_W{trimmed[RAW_W-1]}}, trimmed}
                                 : {{EXT_W{1'b0}}, trimmed};
    end else begin : g_noext
      assign fmtData = trimmed[DATA_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/adc_bank_ctrl.sv
module adc_bank_ctrl
  import adc_bank_pkg::*;
#(
  parameter int NUM_SLOTS = 19,
  parameter bit DBL_BUF   = 1'b1
) (
  input  logic                 cvtStb,
  input  logic [SLOT_W-1:0]    cvtSlot,
  input  logic                 dblMode,
  input  logic                 rdEn,
  input  logic [SLOT_W-1:0]    rdSlot,
  input  logic                 rdSec,
  input  logic [NUM_SLOTS-1:0] priValid,
  output bankCmd_t             cmd
);

  logic wrInRange;
  logic rdInRange;
  logic priBusy;
  logic toSec;

  always_comb begin
    priBusy = 1'b0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (cvtSlot == SLOT_W'(s)) priBusy = priValid[s];
    end
  end

  assign wrInRange = (int'(cvtSlot) < NUM_SLOTS);
  assign rdInRange = (int'(rdSlot) < NUM_SLOTS);
  assign toSec     = DBL_BUF && dblMode && priBusy;

  always_comb begin
    cmd          = '0;
    cmd.wrSlot   = cvtSlot;
    cmd.rdSlot   = rdSlot;
    cmd.rdSecSel = rdSec && DBL_BUF;
    cmd.wrPri    = cvtStb && wrInRange && !toSec;
    cmd.wrSec    = cvtStb && wrInRange && toSec;
    cmd.clrPri   = rdEn && rdInRange && !rdSec;
    cmd.clrSec   = rdEn && rdInRange && rdSec && DBL_BUF;
  end

endmodule

// File: rtl/adc_bank_data.sv
module adc_bank_data
  import adc_bank_pkg::*;
#(
  parameter int NUM_SLOTS  = 19,
  parameter bit DBL_BUF    = 1'b1,
  parameter int STAT_SLOTS = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  bankCmd_t                  cmd,
  input  logic [DATA_W-1:0]         fmtData,
  output logic [NUM_SLOTS-1:0]      priValid,
  output logic [DATA_W+1:0]         rdData,
  output logic                      anyValid,
  output logic                      anyOverrun,
  output logic [2*STAT_SLOTS-1:0]   statusWord
);

  logic [DATA_W-1:0]    priData [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] priOv;
  logic [NUM_SLOTS-1:0] priWr, priClr;

  logic [DATA_W-1:0]    secData [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] secValid, secOv;
  logic [NUM_SLOTS-1:0] secWr, secClr;

  always_comb begin
    for (int s = 0; s < NUM_SLOTS; s++) begin
      priWr[s]  = cmd.wrPri  && (cmd.wrSlot == SLOT_W'(s));
      priClr[s] = cmd.clrPri && (cmd.rdSlot == SLOT_W'(s));
      secWr[s]  = cmd.wrSec  && (cmd.wrSlot == SLOT_W'(s));
      secClr[s] = cmd.clrSec && (cmd.rdSlot == SLOT_W'(s));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SLOTS; s++) priData[s] <= '0;
      priValid <= '0;
      priOv    <= '0;
    end else begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (priWr[s]) begin
          priData[s]  <= fmtData;
          priValid[s] <= 1'b1;
          priOv[s]    <= !priClr[s] && (priOv[s] || priValid[s]);
        end else if (priClr[s]) begin
          priValid[s] <= 1'b0;
          priOv[s]    <= 1'b0;
        end
      end
    end
  end

  generate
    if (DBL_BUF) begin : g_sec
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int s = 0; s < NUM_SLOTS; s++) secData[s] <= '0;
          secValid <= '0;
          secOv    <= '0;
        end else begin
          for (int s = 0; s < NUM_SLOTS; s++) begin
            if (secWr[s]) begin
              secData[s]  <= fmtData;
              secValid[s] <= 1'b1;
              secOv[s]    <= !secClr[s] && (secOv[s] || secValid[s]);
            end else if (secClr[s]) begin
              secValid[s] <= 1'b0;
              secOv[s]    <= 1'b0;
            end
          end
        end
      end
    end else begin : g_nosec
      always_comb begin
        for (int s = 0; s < NUM_SLOTS; s++) secData[s] = '0;
        secValid = '0;
        secOv    = '0;
      end
    end
  endgenerate

  always_comb begin
    rdData = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (cmd.rdSlot == SLOT_W'(s)) begin
        rdData = cmd.rdSecSel ? {secValid[s], secOv[s], secData[s]}
                              : {priValid[s], priOv[s], priData[s]};
      end
    end
  end

  assign anyValid   = (|priValid) || (|secValid);
  assign anyOverrun = (|priOv) || (|secOv);

  always_comb begin
    for (int i = 0; i < STAT_SLOTS; i++) begin
      statusWord[i]              = priValid[i];
      statusWord[STAT_SLOTS + i] = priOv[i];
    end
  end

  // Per-slot flag behaviour guards.
  generate
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_chk
      p_valid_set_r3: assert property (@(posedge clk) disable iff (!rstN)
        priWr[s] |=> priValid[s]);
      p_overrun_set_r4: assert property (@(posedge clk) disable iff (!rstN)
        (priWr[s] && priValid[s] && !priClr[s]) |=> priOv[s]);
      p_ov_needs_valid_r4: assert property (@(posedge clk) disable iff (!rstN)
        priOv[s] |-> priValid[s]);
      p_read_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
        (priClr[s] && !priWr[s]) |=> (!priValid[s] && !priOv[s]));
      p_collide_r9: assert property (@(posedge clk) disable iff (!rstN)
        (priWr[s] && priClr[s]) |=> (priValid[s] && !priOv[s]));
      p_route_sec_r10: assert property (@(posedge clk) disable iff (!rstN)
        (cmd.wrSec && cmd.wrSlot == SLOT_W'(s)) |-> priValid[s]);
    end
  endgenerate

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
  import adc_bank_pkg::*;
#(
  parameter int NUM_SLOTS  = 19,
  parameter bit DBL_BUF    = 1'b1,
  parameter int STAT_SLOTS = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cvtStb,
  input  logic [SLOT_W-1:0]       cvtSlot,
  input  logic [RAW_W-1:0]        cvtRaw,
  input  logic [1:0]              cvtRes,
  input  logic                    cvtSigned,
  input  logic                    dblMode,
  input  logic                    rdEn,
  input  logic [SLOT_W-1:0]       rdSlot,
  input  logic                    rdSec,
  output logic [DATA_W+1:0]       rdData,
  output logic                    anyValid,
  output logic                    anyOverrun,
  output logic [2*STAT_SLOTS-1:0] statusWord
);

  bankCmd_t             cmd;
  logic [DATA_W-1:0]    fmtData;
  logic [NUM_SLOTS-1:0] priValid;

  adc_result_fmt #(.RAW_W(RAW_W), .DATA_W(DATA_W)) u_fmt (
    .rawCode  (cvtRaw),
    .resSel   (cvtRes),
    .signedFmt(cvtSigned),
    .fmtData  (fmtData)
  );

  adc_bank_ctrl #(.NUM_SLOTS(NUM_SLOTS), .DBL_BUF(DBL_BUF)) u_ctrl (
    .cvtStb  (cvtStb),
    .cvtSlot (cvtSlot),
    .dblMode (dblMode),
    .rdEn    (rdEn),
    .rdSlot  (rdSlot),
    .rdSec   (rdSec),
    .priValid(priValid),
    .cmd     (cmd)
  );

  adc_bank_data #(.NUM_SLOTS(NUM_SLOTS), .DBL_BUF(DBL_BUF),
                  .STAT_SLOTS(STAT_SLOTS)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .fmtData   (fmtData),
    .priValid  (priValid),
    .rdData    (rdData),
    .anyValid  (anyValid),
    .anyOverrun(anyOverrun),
    .statusWord(statusWord)
  );

endmodule

// File: tb/sim_adc_result_bank.sv
`timescale 1ns/100ps
module sim_adc_result_bank;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cvtStb = 1'b0;
  logic [4:0]  cvtSlot = '0;
  logic [11:0] cvtRaw = '0;
  logic [1:0]  cvtRes = '0;
  logic        cvtSigned = 1'b0;
  logic        dblMode = 1'b0;
  logic        rdEn = 1'b0;
  logic [4:0]  rdSlot = '0;
  logic        rdSec = 1'b0;
  logic [17:0] rdData;
  logic        anyValid, anyOverrun;
  logic [31:0] statusWord;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  adc_result_bank u0 (
    .clk(clk), .rstN(rstN), .cvtStb(cvtStb), .cvtSlot(cvtSlot),
    .cvtRaw(cvtRaw), .cvtRes(cvtRes), .cvtSigned(cvtSigned),
    .dblMode(dblMode), .rdEn(rdEn), .rdSlot(rdSlot), .rdSec(rdSec),
    .rdData(rdData), .anyValid(anyValid), .anyOverrun(anyOverrun),
    .statusWord(statusWord)
  );

  // {slot[4:0], raw[11:0], res[1:0], signed, expected result[15:0]}
  localparam logic [35:0] VEC [8] = '{
    {5'd0,  12'hABC, 2'd3, 1'b0, 16'h0ABC},   // R1
    {5'd1,  12'hABC, 2'd3, 1'b1, 16'hFABC},   // R2
    {5'd2,  12'h7FF, 2'd3, 1'b1, 16'h07FF},   // R2
    {5'd3,  12'hFFF, 2'd0, 1'b1, 16'h003F},   // R6
    {5'd18, 12'hFFF, 2'd1, 1'b0, 16'h00FF},   // R6
    {5'd7,  12'hF55, 2'd2, 1'b1, 16'h0355},   // R6
    {5'd15, 12'h800, 2'd3, 1'b1, 16'hF800},   // R2
    {5'd16, 12'h123, 2'd0, 1'b0, 16'h0023}    // R6
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic convert(input logic [4:0] s, input logic [11:0] raw,
                         input logic [1:0] res, input logic sgn);
    @(negedge clk);
    cvtStb = 1'b1; cvtSlot = s; cvtRaw = raw; cvtRes = res; cvtSigned = sgn;
    @(posedge clk);
    #1 cvtStb = 1'b0;
  endtask

  task automatic readSlot(input logic [4:0] s, input logic sec, output logic [17:0] val);
    @(negedge clk);
    rdEn = 1'b1; rdSlot = s; rdSec = sec;
    #1 val = rdData;
    @(posedge clk);
    #1 rdEn = 1'b0; rdSec = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [17:0] v;
    repeat (3) @(negedge clk);
    #1;
    // Reset state
    chk("R7 reset anyValid", 32'(anyValid), 32'd0);
    chk("R7 reset anyOverrun", 32'(anyOverrun), 32'd0);
    chk("R8 reset statusWord", statusWord, 32'd0);
    chk("R3 reset rdData", 32'(rdData), 32'd0);
    @(negedge clk) rstN = 1'b1;

    // Vector table walk: R1 R2 R3 R5 R6 R7
    for (int i = 0; i < 8; i++) begin
      convert(VEC[i][35:31], VEC[i][30:19], VEC[i][18:17], VEC[i][16]);
      @(negedge clk);
      chk("R7 anyValid after write", 32'(anyValid), 32'd1);
      readSlot(VEC[i][35:31], 1'b0, v);
      chk("R3 R1 R2 R6 read word", 32'(v), {14'd0, 2'b10, VEC[i][15:0]});
      @(negedge clk);
      chk("R5 R7 anyValid after read", 32'(anyValid), 32'd0);
      readSlot(VEC[i][35:31], 1'b0, v);
      chk("R5 flags cleared data kept", 32'(v), {14'd0, 2'b00, VEC[i][15:0]});
    end

    // Overrun on slot 4: R4 R7 R8
    convert(5'd4, 12'h100, 2'd3, 1'b0);
    convert(5'd4, 12'h200, 2'd3, 1'b0);
    @(negedge clk);
    chk("R7 anyOverrun set", 32'(anyOverrun), 32'd1);
    chk("R8 statusWord slot4", statusWord, 32'h0010_0010);
    readSlot(5'd4, 1'b0, v);
    chk("R4 overrun read word", 32'(v), 32'h30200);
    @(negedge clk);
    chk("R5 R7 anyOverrun cleared", 32'(anyOverrun), 32'd0);
    chk("R8 statusWord cleared", statusWord, 32'd0);

    // Same-cycle write and read: R9
    convert(5'd5, 12'h111, 2'd3, 1'b0);
    @(negedge clk);
    cvtStb = 1'b1; cvtSlot = 5'd5; cvtRaw = 12'h222; cvtRes = 2'd3; cvtSigned = 1'b0;
    rdEn = 1'b1; rdSlot = 5'd5; rdSec = 1'b0;
    #1 chk("R9 collision read old", 32'(rdData), 32'h20111);
    @(posedge clk);
    #1 cvtStb = 1'b0; rdEn = 1'b0;
    readSlot(5'd5, 1'b0, v);
    chk("R9 collision new valid no ov", 32'(v), 32'h20222);

    // Double buffer routing: R10
    dblMode = 1'b1;
    convert(5'd6, 12'h0AA, 2'd3, 1'b0);
    convert(5'd6, 12'h0BB, 2'd3, 1'b0);
    readSlot(5'd6, 1'b1, v);
    chk("R10 second register", 32'(v), 32'h200BB);
    readSlot(5'd6, 1'b0, v);
    chk("R10 primary kept no ov", 32'(v), 32'h200AA);
    readSlot(5'd6, 1'b1, v);
    chk("R5 second register cleared", 32'(v), 32'h000BB);
    convert(5'd6, 12'h0CC, 2'd3, 1'b0);
    readSlot(5'd6, 1'b0, v);
    chk("R10 empty primary takes result", 32'(v), 32'h200CC);

    // Mode off: R11
    dblMode = 1'b0;
    convert(5'd8, 12'h011, 2'd3, 1'b0);
    convert(5'd8, 12'h022, 2'd3, 1'b0);
    readSlot(5'd8, 1'b1, v);
    chk("R11 second register untouched", 32'(v), 32'h00000);
    readSlot(5'd8, 1'b0, v);
    chk("R11 R4 primary overrun", 32'(v), 32'h30022);
    @(negedge clk);
    chk("R7 all clear at end", {30'd0, anyValid, anyOverrun}, 32'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule